// File: doc/BRIEF.md
# Embedded-Sync Video Stream Decoder

This block takes an 8-bit BT.656 byte stream for 625-line, 720x576 interlaced video. It needs no separate sync pins. It finds the four-byte timing reference codes carried inside the data, and it checks the protection bits of each status word. It then recovers the field identity and the vertical-blanking state from the codes.

After a valid start-of-active-video code on an active line, the decoder counts the 1440 bytes of picture data. It turns each group of four bytes into one 4:2:2 pixel pair, made of two luma samples that share one chroma pair. It also keeps two counters for downstream logic:

- an active-line index, which restarts at every field change;
- a pixel-pair column within the line.

A corrupted status word, or a line that ends early, produces a one-cycle error pulse. The decoder then drops the rest of that line and resumes at the next good start code.

Video arrives at a fixed byte rate, one byte per clock, and cannot be stalled. The output stream therefore has a valid strobe and no ready. The consumer must accept every pair in the cycle it is presented. Control and status outputs are plain levels or pulses.

Top module: `embsync_video_decoder`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first code is seen, the outputs are: `pix_valid` 0, `sync_error` 0, `field_id` 0, `vblank` 1, `active_line` 0.
- R2: A code is the bytes 0xFF, 0x00, 0x00, then a status byte S. S decodes as F = S[6], V = S[5], H = S[4]. S is good only if S[7] = 1 and S[3:0] = {V^H, F^H, F^V, F^V^H}. For each good code, `field_id` and `vblank` show F and V from the cycle after S is sampled.
- R3: After reset, no pair is emitted until a good code with H = 1 (end of line) has been seen, followed by a good code with H = 0 and V = 0.
- R4: After a good code with H = 0 and V = 0, the next 1440 bytes are taken in the order Cb, Y0, Cr, Y1. One cycle after the fourth byte of each group, `pix_valid` pulses with that group on `pix_cb`, `pix_y0`, `pix_cr` and `pix_y1`. `pair_col` runs from 0 up to 359.
- R5: A good code with H = 0 and V = 1 starts no pixel output. `pix_valid` is never high while `vblank` is high.
- R6: A status byte that fails the check in R2 raises `sync_error` for exactly one cycle, in the cycle after that byte. It leaves `field_id`, `vblank` and `active_line` unchanged, and it ends any line in progress.
- R7: A code that completes before all 1440 bytes of a line have arrived raises the same one-cycle `sync_error` pulse. No further pairs are emitted until the next good start code.
- R8: A good code whose F differs from `field_id` clears `active_line` to 0. A good end code with V = 0 and an unchanged F increments `active_line` by one.
- R9: Once the first end code has been seen, a good start code that follows an error resumes pixel output at once. No further end code is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, one stream byte per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_byte | input | 8 | Incoming BT.656 byte stream |
| pix_valid | output | 1 | One-cycle strobe: a pixel pair is on the data outputs |
| pix_cb | output | 8 | Shared blue-difference chroma of the pair |
| pix_y0 | output | 8 | Luma of the first pixel |
| pix_cr | output | 8 | Shared red-difference chroma of the pair |
| pix_y1 | output | 8 | Luma of the second pixel |
| pair_col | output | 9 | Index of the pair within the line, 0 to 359 |
| field_id | output | 1 | Field bit of the last good code |
| vblank | output | 1 | Vertical-blanking bit of the last good code |
| active_line | output | 9 | Active line index within the current field |
| sync_error | output | 1 | One-cycle pulse on a bad status byte or a short line |

## Verification
The assertions assume three things about the input:
- the stream carries a new byte on every clock;
- picture data never forms the byte triple 0xFF, 0x00, 0x00;
- nothing is ever presented downstream that would need a stall.

On that basis, codes are always at least four cycles apart, and no pair can appear during blanking. The stimulus keeps within these rules:
- payload bytes are drawn only from the range 0x10 to 0xD7;
- blanking uses the alternating 0x80 and 0x10 filler;
- every code is sent whole.

Errors are introduced only as corrupted status bytes, a line truncated after 600 bytes, and start codes sent before any end code.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SYNCED = 2'd1,
    ST_ACTIVE = 2'd2
  } sync_state_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
    logic ok;
  } trs_info_t;

  // Expected protection nibble for a status word with flags f, v, h.
  function automatic logic [3:0] prot_nibble(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/embsync_trs_detect.sv
module embsync_trs_detect
  import embsync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] byte_in,
  output logic              trs_hit,
  output trs_info_t         trs_info
);

  localparam int HIST = 3;
  localparam int SLSB = DATA_W - 8;

  logic [DATA_W-1:0] hist_q [HIST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= byte_in;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // hist_q[2] is the oldest of the three previous bytes.
  assign trs_hit = (hist_q[2] == '1) && (hist_q[1] == '0) && (hist_q[0] == '0);

  logic [7:0] status;
  assign status     = byte_in[SLSB +: 8];
  assign trs_info.f = status[6];
  assign trs_info.v = status[5];
  assign trs_info.h = status[4];
  assign trs_info.ok = status[7] &&
                       (status[3:0] == prot_nibble(status[6], status[5], status[4]));

  AST_TRS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    trs_hit |=> !trs_hit); // R2

endmodule

// File: rtl/embsync_sync_fsm.sv
module embsync_sync_fsm
  import embsync_pkg::*;
#(
  parameter int ACTIVE_BYTES = 1440,
  parameter int LINE_W       = 9,
  parameter int CNT_W        = $clog2(ACTIVE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trs_hit,
  input  trs_info_t         trs_info,
  output logic              take_byte,
  output logic [CNT_W-1:0]  byte_idx,
  output logic              field_id,
  output logic              vblank,
  output logic [LINE_W-1:0] active_line,
  output logic              sync_error
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ACTIVE_BYTES - 1);

  sync_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  assign take_byte = (state_q == ST_ACTIVE) && !trs_hit;
  assign byte_idx  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HUNT;
      cnt_q       <= '0;
      field_id    <= 1'b0;
      vblank      <= 1'b1;
      active_line <= '0;
      sync_error  <= 1'b0;
    end else begin
      sync_error <= 1'b0;
      if (trs_hit) begin
        if (!trs_info.ok) begin
          sync_error <= 1'b1;
          if (state_q == ST_ACTIVE) state_q <= ST_SYNCED;
        end else begin
          vblank <= trs_info.v;
          if (trs_info.f != field_id) begin
            field_id    <= trs_info.f;
            active_line <= '0;
          end else if (trs_info.h && !trs_info.v) begin
            active_line <= active_line + 1'b1;
          end
          unique case (state_q)
            ST_ACTIVE: begin
              sync_error <= 1'b1;
              state_q    <= ST_SYNCED;
            end
            ST_HUNT: if (trs_info.h) state_q <= ST_SYNCED;
            default: if (!trs_info.h && !trs_info.v) begin
              state_q <= ST_ACTIVE;
              cnt_q   <= '0;
            end
          endcase
        end
      end else if (state_q == ST_ACTIVE) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) state_q <= ST_SYNCED;
      end
    end
  end

  AST_HUNT_NO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT) |=> (state_q != ST_ACTIVE)); // R3

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_error |=> !sync_error); // R6

endmodule

// File: rtl/embsync_pair_demux.sv
module embsync_pair_demux #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 11,
  parameter int COL_W  = 9,
  parameter int PAIRS  = 360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_byte,
  input  logic [CNT_W-1:0]  byte_idx,
  input  logic [DATA_W-1:0] byte_in,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_cb,
  output logic [DATA_W-1:0] pix_y0,
  output logic [DATA_W-1:0] pix_cr,
  output logic [DATA_W-1:0] pix_y1,
  output logic [COL_W-1:0]  pair_col
);

  logic [DATA_W-1:0] cb_q, y0_q, cr_q;
  logic [1:0] lane;
  assign lane = byte_idx[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_q      <= '0;
      y0_q      <= '0;
      cr_q      <= '0;
      pix_valid <= 1'b0;
      pix_cb    <= '0;
      pix_y0    <= '0;
      pix_cr    <= '0;
      pix_y1    <= '0;
      pair_col  <= '0;
    end else begin
      pix_valid <= 1'b0;
      if (take_byte) begin
        unique case (lane)
          2'd0: cb_q <= byte_in;
          2'd1: y0_q <= byte_in;
          2'd2: cr_q <= byte_in;
          default: begin
            pix_valid <= 1'b1;
            pix_cb    <= cb_q;
            pix_y0    <= y0_q;
            pix_cr    <= cr_q;
            pix_y1    <= byte_in;
            pair_col  <= COL_W'(byte_idx >> 2);
          end
        endcase
      end
    end
  end

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (int'(pair_col) < PAIRS)); // R4

  AST_PAIR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid); // R4

endmodule

// File: rtl/embsync_video_decoder.sv
module embsync_video_decoder
  import embsync_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ACTIVE_BYTES = 1440,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] vid_byte,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_cb,
  output logic [DATA_W-1:0] pix_y0,
  output logic [DATA_W-1:0] pix_cr,
  output logic [DATA_W-1:0] pix_y1,
  output logic [8:0]        pair_col,
  output logic              field_id,
  output logic              vblank,
  output logic [LINE_W-1:0] active_line,
  output logic              sync_error
);

  localparam int CNT_W = $clog2(ACTIVE_BYTES + 1);
  localparam int PAIRS = ACTIVE_BYTES / 4;
  localparam int COL_W = 9;

  logic             trs_hit;
  trs_info_t        trs_info;
  logic             take_byte;
  logic [CNT_W-1:0] byte_idx;

  embsync_trs_detect #(.DATA_W(DATA_W)) u_trs (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_in  (vid_byte),
    .trs_hit  (trs_hit),
    .trs_info (trs_info)
  );

  embsync_sync_fsm #(
    .ACTIVE_BYTES (ACTIVE_BYTES),
    .LINE_W       (LINE_W),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trs_hit     (trs_hit),
    .trs_info    (trs_info),
    .take_byte   (take_byte),
    .byte_idx    (byte_idx),
    .field_id    (field_id),
    .vblank      (vblank),
    .active_line (active_line),
    .sync_error  (sync_error)
  );

  embsync_pair_demux #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .COL_W  (COL_W),
    .PAIRS  (PAIRS)
  ) u_demux (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_byte (take_byte),
    .byte_idx  (byte_idx),
    .byte_in   (vid_byte),
    .pix_valid (pix_valid),
    .pix_cb    (pix_cb),
    .pix_y0    (pix_y0),
    .pix_cr    (pix_cr),
    .pix_y1    (pix_y1),
    .pair_col  (pair_col)
  );

  AST_BLANK_NO_PIXELS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !vblank); // R5

endmodule

// File: tb/embsync_video_decoder_tb.sv
`timescale 1ns/1ps
module embsync_video_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] vid_byte = 8'h80;
  logic       pix_valid, field_id, vblank, sync_error;
  logic [7:0] pix_cb, pix_y0, pix_cr, pix_y1;
  logic [8:0] pair_col, active_line;

  always #2.5 clk = ~clk;

  embsync_video_decoder u_dut (
    .clk (clk), .rst_n (rst_n), .vid_byte (vid_byte),
    .pix_valid (pix_valid), .pix_cb (pix_cb), .pix_y0 (pix_y0),
    .pix_cr (pix_cr), .pix_y1 (pix_y1), .pair_col (pair_col),
    .field_id (field_id), .vblank (vblank), .active_line (active_line),
    .sync_error (sync_error)
  );

  int vectors = 0;
  int fails   = 0;

  // Behavioural reference model
  logic [7:0] hist[$];
  int  m_mode;          // 0 hunting, 1 locked, 2 inside a line
  int  m_pos;
  logic m_valid, m_err, m_field, m_vblank;
  int  m_line;
  logic [7:0] m_cb, m_y0, m_cr, m_y1, g_cb, g_y0, g_cr;
  int  m_col;

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      m_mode = 0; m_pos = 0; m_valid = 0; m_err = 0;
      m_field = 0; m_vblank = 1; m_line = 0; m_col = 0;
    end else begin
      logic [7:0] b;
      b = vid_byte;
      m_valid = 0; m_err = 0;
      if (hist.size() == 3 && hist[0] == 8'hFF && hist[1] == 8'h00 && hist[2] == 8'h00) begin
        if (b != xy(b[6], b[5], b[4])) begin
          m_err = 1;
          if (m_mode == 2) m_mode = 1;
        end else begin
          m_vblank = b[5];
          if (b[6] != m_field) begin m_field = b[6]; m_line = 0; end
          else if (b[4] && !b[5]) m_line = (m_line + 1) % 512;
          if (m_mode == 2) begin m_err = 1; m_mode = 1; end
          else if (m_mode == 0) begin if (b[4]) m_mode = 1; end
          else if (!b[4] && !b[5]) begin m_mode = 2; m_pos = 0; end
        end
      end else if (m_mode == 2) begin
        case (m_pos % 4)
          0: g_cb = b;
          1: g_y0 = b;
          2: g_cr = b;
          default: begin
            m_valid = 1; m_cb = g_cb; m_y0 = g_y0; m_cr = g_cr; m_y1 = b;
            m_col = m_pos / 4;
          end
        endcase
        m_pos++;
        if (m_pos == 1440) m_mode = 1;
      end
      hist.push_back(b);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(pix_valid === m_valid, "R4 R5 pix_valid", int'(pix_valid), int'(m_valid));
    if (m_valid) begin
      chk(pix_cb === m_cb, "R4 cb", pix_cb, m_cb);
      chk(pix_y0 === m_y0, "R4 y0", pix_y0, m_y0);
      chk(pix_cr === m_cr, "R4 cr", pix_cr, m_cr);
      chk(pix_y1 === m_y1, "R4 y1", pix_y1, m_y1);
      chk(int'(pair_col) == m_col, "R4 pair_col", pair_col, m_col);
    end
    chk(sync_error === m_err, "R6 R7 sync_error", int'(sync_error), int'(m_err));
    chk(field_id === m_field, "R2 field_id", int'(field_id), int'(m_field));
    chk(vblank === m_vblank, "R2 R5 vblank", int'(vblank), int'(m_vblank));
    chk(int'(active_line) == m_line, "R8 active_line", active_line, m_line);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    compare();
    vid_byte = b;
  endtask

  task automatic code(input logic [7:0] s);
    put(8'hFF); put(8'h00); put(8'h00); put(s);
  endtask

  // One line: end code, horizontal blanking, start code, n payload bytes.
  task automatic line(input logic [7:0] eav, input logic [7:0] sav,
                      input int n, input bit blank, input int seed);
    code(eav);
    for (int i = 0; i < 280; i++) put(i[0] ? 8'h10 : 8'h80);
    code(sav);
    for (int i = 0; i < n; i++)
      put(blank ? (i[0] ? 8'h10 : 8'h80) : 8'(16 + ((seed * 37 + i * 11) % 200)));
  endtask

  task automatic run_all();
    #12 rst_n = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pix_valid === 1'b0 && sync_error === 1'b0, "R1 strobes", int'(pix_valid), 0);
    chk(field_id === 1'b0 && vblank === 1'b1, "R1 flags", {field_id, vblank}, 1);
    chk(active_line === '0, "R1 active_line", active_line, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) put(i[0] ? 8'h10 : 8'h80);
    // R3: start code with payload before any end code yields no pairs
    code(xy(0, 0, 0));
    for (int i = 0; i < 40; i++) put(8'(40 + i));
    line(xy(0, 1, 1), xy(0, 1, 0), 1440, 1'b1, 0);     // R5 blank line
    line(xy(0, 1, 1), xy(0, 0, 0), 1440, 1'b0, 1);     // R4
    line(xy(0, 0, 1), xy(0, 0, 0), 1440, 1'b0, 2);     // R8 increments
    line(xy(0, 0, 1), xy(0, 0, 0), 1440, 1'b0, 3);
    line(8'h9C,       xy(0, 0, 0), 1440, 1'b0, 4);     // R6 bad end, R9 resume
    line(xy(0, 0, 1), 8'h81,       1440, 1'b0, 5);     // R6 bad start, no pairs
    line(xy(0, 0, 1), xy(0, 0, 0), 600,  1'b0, 6);     // short line
    line(xy(0, 0, 1), xy(0, 0, 0), 1440, 1'b0, 7);     // R7 error at this end code
    line(xy(1, 1, 1), xy(1, 1, 0), 1440, 1'b1, 8);     // R8 field change
    line(xy(1, 1, 1), xy(1, 0, 0), 1440, 1'b0, 9);
    line(xy(1, 0, 1), xy(1, 0, 0), 1440, 1'b0, 10);
    line(xy(0, 1, 1), xy(0, 1, 0), 1440, 1'b1, 11);
    code(xy(0, 1, 1));
    for (int i = 0; i < 8; i++) put(8'h80);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule